// File: doc/BRIEF.md
# I2C Client Address-Match Status Monitor

This block listens passively to an I2C clock and data pair that arrives asynchronously to the system clock. Both lines are synchronized, and the block watches for Start, repeated Start and Stop conditions. It shifts in every byte on the bus and compares each address byte with a configured own address, in either 7-bit or 10-bit form. It never drives the bus. It produces four status flags that a surrounding client controller can read: an idle-bus indication, a client-selected indication, the direction of the last matching address, and whether the last completed byte was data or address.

In 10-bit mode the whole addressing sequence is followed. A high address byte with the write bit, followed by a matching low byte, selects the client and arms it. A later high address byte with the read bit, sent after a repeated Start, selects the client again for reading only while that arming is still in place. A Stop removes the arming. The idle threshold is an input, so software can tune the bus-free time without resynthesis.

Top module: `i2c_client_status_mon`

## Requirements
- R1: `bus_free` is 1 only after both synchronized lines have been high for more than `idle_limit` system cycles; a low level on either line returns it to 0 and restarts the count.
- R2: In 7-bit mode (`ten_bit` = 0), the first byte after a Start is `{addr[6:0], rw}` sent MSB first and sampled on the SCL rising edges. If `addr` equals `own_addr[6:0]`, `client_active` goes to 1 on that byte's 8th falling SCL edge.
- R3: In 10-bit mode, a high byte `11110 a9 a8 0` whose `a9 a8` equal `own_addr[9:8]`, followed by a low byte equal to `own_addr[7:0]`, sets `client_active` on the low byte's 8th falling SCL edge and arms a read re-address.
- R4: In 10-bit mode, a first byte `11110 a9 a8 1` with matching bits raises `client_active` only while armed. A Stop discards the arming.
- R5: A Start (SDA falls while SCL is high) or a Stop (SDA rises while SCL is high) clears `client_active`, and a repeated Start within a transfer clears it too.
- R6: `read_flag` takes the R/W bit of the most recent matching address. In 10-bit mode this is 0 for the low-byte match and 1 for the high-byte read match. A non-matching address leaves it unchanged.
- R7: `data_flag` is 0 after an address byte and 1 after a data byte. The first byte after a Start is an address byte, and so is the byte right after a 10-bit high byte with the write bit. Every other byte is data.
- R8: After reset all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own client address (7-bit mode uses bits 6:0) |
| idle_limit | input | IDLE_W | Idle cycles required before bus free |
| bus_free | output | 1 | Bus idle status |
| client_active | output | 1 | Client selected by a matching address |
| read_flag | output | 1 | Direction of last matching address, 1 = read |
| data_flag | output | 1 | Last byte was data (1) or address (0) |

## Verification
The bench uses the default `IDLE_W` of 8 and drives `idle_limit` to 20. With that setting the bus-free flag rises within a short gap between transfers, and it stays low during every bus phase, which is held for 10 system cycles. The own address 0x2A5 is chosen so that a single value covers the 7-bit match (0x25) and both 10-bit bytes (high bits `10`, low byte 0xA5). This lets the tests switch modes between transfers without reprogramming the address, and it brings the armed read re-address, its loss on Stop, and non-matching reads within reach.

// File: rtl/i2c_client_status_mon.sv
module i2c_client_status_mon #(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              ten_bit,
  input  logic [9:0]        own_addr,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              bus_free,
  output logic              client_active,
  output logic              read_flag,
  output logic              data_flag
);

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  wire        scl_s = scl_sy[1];
  wire        sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  // bus idle timer
  logic [IDLE_W-1:0] idle_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idle_cnt <= '0; bus_free <= 1'b0;
    end else if (!(scl_s && sda_s)) begin
      idle_cnt <= '0; bus_free <= 1'b0;
    end else if (idle_cnt == idle_limit) begin
      bus_free <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end

  // bit and byte framing
  logic       in_xfer, first_byte, next_low, hi_ok, armed;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  wire        byte_done = in_xfer && scl_fall && (bit_cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_xfer <= 1'b0; bit_cnt <= '0; shreg <= '0;
    end else if (start_c) begin
      in_xfer <= 1'b1; bit_cnt <= '0;
    end else if (stop_c) begin
      in_xfer <= 1'b0; bit_cnt <= '0;
    end else if (in_xfer) begin
      if (scl_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
      end else if (scl_fall && bit_cnt == 4'd9) begin
        bit_cnt <= '0;
      end
    end

  // address decode
  wire prefix    = shreg[7:3] == 5'b11110;
  wire hi_match  = prefix && (shreg[2:1] == own_addr[9:8]);
  wire m7        = !ten_bit && first_byte && (shreg[7:1] == own_addr[6:0]);
  wire m10_low   = ten_bit && !first_byte && next_low && hi_ok && (shreg == own_addr[7:0]);
  wire m10_read  = ten_bit && first_byte && hi_match && shreg[0] && armed;
  wire is_addr   = first_byte || (ten_bit && next_low);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      first_byte <= 1'b0; next_low <= 1'b0; hi_ok <= 1'b0; armed <= 1'b0;
      client_active <= 1'b0; read_flag <= 1'b0; data_flag <= 1'b0;
    end else if (start_c || stop_c) begin
      client_active <= 1'b0;
      first_byte    <= start_c;
      next_low      <= 1'b0;
      if (stop_c) armed <= 1'b0;
    end else if (byte_done) begin
      first_byte <= 1'b0;
      data_flag  <= !is_addr;
      next_low   <= ten_bit && first_byte && prefix && !shreg[0];
      hi_ok      <= hi_match;
      if (ten_bit && first_byte && prefix && !shreg[0]) armed <= 1'b0;
      if (m7) begin
        client_active <= 1'b1; read_flag <= shreg[0];
      end else if (m10_low) begin
        client_active <= 1'b1; read_flag <= 1'b0; armed <= 1'b1;
      end else if (m10_read) begin
        client_active <= 1'b1; read_flag <= 1'b1;
      end
    end

  assert_idle_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_s && sda_s) |=> !bus_free);
  assert_active_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(client_active) |-> $past(byte_done));
  assert_active_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !client_active);
  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(read_flag));
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(data_flag));
  assert_stop_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !armed);

endmodule

// File: tb/test_i2c_client_status_mon.sv
module test_i2c_client_status_mon;
  localparam int IDLE_W = 8;
  localparam int PH = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1, ten = 1'b0;
  logic [9:0] own = 10'h2A5;
  logic [IDLE_W-1:0] lim = 8'd20;
  logic bus_free, act, rd, dat;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  i2c_client_status_mon #(.IDLE_W(IDLE_W)) i_i2c_client_status_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .ten_bit(ten),
    .own_addr(own), .idle_limit(lim), .bus_free(bus_free),
    .client_active(act), .read_flag(rd), .data_flag(dat));

  // {ten, b0, has_b1, b1, exp_active, exp_read, exp_data}
  localparam logic [20:0] VEC [7] = '{
    {1'b0, 8'h4B, 1'b0, 8'h00, 3'b110},  // R2 R6 read match
    {1'b0, 8'h4A, 1'b1, 8'h13, 3'b101},  // R2 R7 write then data
    {1'b0, 8'h61, 1'b0, 8'h00, 3'b000},  // R6 no match keeps read
    {1'b0, 8'h61, 1'b1, 8'hFF, 3'b001},  // R7 data byte
    {1'b1, 8'hF4, 1'b1, 8'hA5, 3'b100},  // R3 low match
    {1'b1, 8'hF4, 1'b1, 8'hA4, 3'b000},  // R3 R7 low mismatch is address
    {1'b1, 8'hF5, 1'b0, 8'h00, 3'b000}   // R4 read without arming
  };

  task automatic wt(); repeat (PH) @(posedge clk); endtask
  task automatic do_start(); sda = 1; wt(); scl = 1; wt(); sda = 0; wt(); scl = 0; wt(); endtask
  task automatic do_stop(); sda = 0; wt(); scl = 1; wt(); sda = 1; wt(); endtask
  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda = b[i]; wt(); scl = 1; wt(); scl = 0; wt();
    end
    sda = 1; wt(); scl = 1; wt(); scl = 0; wt();
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    @(negedge clk);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    chk("R8 bus_free", bus_free, 1'b0);
    chk("R8 active", act, 1'b0);
    chk("R8 read", rd, 1'b0);
    chk("R8 data", dat, 1'b0);
    rst_n = 1;
    repeat (40) @(posedge clk);
    chk("R1 idle bus free", bus_free, 1'b1);

    for (int v = 0; v < 7; v++) begin
      ten = VEC[v][20];
      do_start();
      chk("R1 busy bus not free", bus_free, 1'b0);
      send(VEC[v][19:12]);
      if (VEC[v][11]) send(VEC[v][10:3]);
      chk($sformatf("R2 vector %0d active", v), act, VEC[v][2]);
      chk($sformatf("R6 vector %0d read", v), rd, VEC[v][1]);
      chk($sformatf("R7 vector %0d data", v), dat, VEC[v][0]);
      do_stop();
      chk("R5 stop clears active", act, 1'b0);
      repeat (40) @(posedge clk);
    end

    // R4 armed re-address through restart
    ten = 1;
    do_start(); send(8'hF4); send(8'hA5);
    chk("R3 low match active", act, 1'b1);
    do_start();
    chk("R5 restart clears active", act, 1'b0);
    send(8'hF5);
    chk("R4 armed read active", act, 1'b1);
    chk("R6 armed read flag", rd, 1'b1);
    chk("R7 high byte is address", dat, 1'b0);
    send(8'h77);
    chk("R7 data after read", dat, 1'b1);
    do_stop();
    chk("R5 stop after read", act, 1'b0);
    repeat (40) @(posedge clk);
    do_start(); send(8'hF5);
    chk("R4 arming lost after stop", act, 1'b0);
    do_stop();

    // R2 address match ignored as data byte
    ten = 0;
    repeat (40) @(posedge clk);
    do_start(); send(8'h60); send(8'h4A);
    chk("R2 match in data position ignored", act, 1'b0);
    chk("R7 second byte data", dat, 1'b1);
    do_stop();
    repeat (40) @(posedge clk);
    chk("R1 free again", bus_free, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule